// File: doc/BRIEF.md
# Decrement-and-Skip Instruction Executor

This block carries out the two byte-oriented "decrement a file register, then maybe skip" instructions of a small microcontroller core. A 16-bit instruction word is accepted with a one-cycle `start` pulse while the block is idle. The block then walks through one instruction cycle of four clock phases. In Q1 it decodes the word. In Q2 it forms a 12-bit data address and reads the operand through a simple register-file port. In Q3 it decrements the operand, and in Q4 it writes the result either to the working register or back to the file register.

The opcode sets the sense of the skip test. One form skips when the result is zero, the other when it is nonzero. When the test holds, the block raises `flush_req` for one no-op instruction cycle, or for two when the following instruction is a two-word instruction. It also reports how many no-op cycles it inserted on `skip_cycles`.

Fetch, the program counter and every other opcode lie outside the block. No status flags are changed. An opcode that is not one of the two supported forms is flagged and does nothing else. `start` is only sampled while `busy` is low. The operand-addressing inputs (`bank_sel`, `idx_base`, `ext_en`) are captured together with the instruction word. `next_two_word` is sampled at the end of Q4.

Top module: `dskip_exec`

## Requirements
- R1: Bits [15:10] equal to 001011 select skip-if-zero and 010011 select skip-if-nonzero. Bit 9 is the destination bit (0 = working register, 1 = file register), bit 8 is the bank-mode bit, and bits [7:0] are the file offset f.
- R2: The clock after an accepted `start` is phase Q1 (`q_phase`=0). Phases then run 0,1,2,3, one per clock. `rf_rd_en` is high only in Q2 and the write strobes are high only in Q4. Without a skip, `busy` is high for exactly 4 clocks.
- R3: The result is (operand − 1) mod 256. An operand of 0x00 gives 0xFF, and that result counts as nonzero.
- R4: In Q4, exactly one of `w_we` (destination bit 0) or `rf_wr_en` (destination bit 1) is high, carrying the result. The file write goes to the same address that was read.
- R5: With the bank-mode bit at 1, the address is {bank_sel[3:0], f}.
- R6: With the bank-mode bit at 0 and indexed mode not in force, f < 0x60 maps to 0x000+f and f ≥ 0x60 maps to 0xF00+f.
- R7: With the bank-mode bit at 0, `ext_en`=1 and f ≤ 0x5F, the address is (idx_base + f) mod 4096.
- R8: When the skip test holds, `flush_req` is high for 4 clocks per no-op cycle right after Q4. There is one no-op cycle, or two when `next_two_word`=1. No write strobe is high during a flush.
- R9: After Q4, `skip_cycles` shows 0, 1 or 2 (the no-op cycles inserted) and holds that value until the next accepted `start`.
- R10: For any other opcode, `illegal` is high from Q2 until the next accepted `start`. No read, no write and no flush occur.
- R11: After reset, `busy`, `flush_req`, `rf_rd_en`, `rf_wr_en`, `w_we`, `illegal` and `skip_cycles` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept `instr` (only while idle) |
| instr | input | 16 | Instruction word |
| ext_en | input | 1 | Extended (indexed) addressing enable |
| bank_sel | input | 4 | Bank select register value |
| idx_base | input | 12 | Index base pointer for indexed mode |
| next_two_word | input | 1 | Following instruction occupies two words |
| rf_addr | output | 12 | Data memory address |
| rf_rd_en | output | 1 | Read strobe (Q2) |
| rf_rdata | input | 8 | Read data, combinational from `rf_addr` |
| rf_wr_en | output | 1 | File write strobe (Q4) |
| rf_wdata | output | 8 | File write data |
| w_we | output | 1 | Working register write strobe (Q4) |
| w_data | output | 8 | Working register write data |
| flush_req | output | 1 | Discard next fetched instruction / no-op cycle |
| skip_cycles | output | 2 | No-op cycles inserted by last instruction |
| illegal | output | 1 | Last instruction was not a supported form |
| busy | output | 1 | Instruction or no-op cycles in progress |
| q_phase | output | 2 | Current phase Q1..Q4 as 0..3 |

## Verification
The bench builds the block with its default parameters: a 4-bit bank field, an 8-bit offset and a split at 0x60, giving 12-bit addresses. Under these values the full cross of opcode (both legal forms and two illegal codes), destination bit, bank-mode bit, extended mode and next-instruction length fits in a short run. That cross is swept over the offsets 0x00, 0x01, 0x5F, 0x60, 0x9A and 0xFF, and over the operands 0x00, 0x01, 0x02, 0x80 and 0xFF. This reaches the access-bank split on both sides, the indexed sum wrapping past 0xFFF with a base of 0xFC0, the 0x00 to 0xFF wrap, and both the one- and two-cycle flush lengths.

// File: rtl/dskip_pkg.sv
// Shared types and decode for the decrement-and-skip executor.
// Assumes a 16-bit instruction word with the opcode in the top six bits.
package dskip_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_NOP  = 2'd2
    } seq_state_e;

    localparam logic [5:0] OPC_DEC_SKIP_Z  = 6'b001011;
    localparam logic [5:0] OPC_DEC_SKIP_NZ = 6'b010011;

    typedef struct packed {
        logic       legal;
        logic       zero_form;
        logic       to_file;
        logic       use_bank;
        logic [7:0] foff;
    } dec_t;

    // Split an instruction word into its control fields.
    function automatic dec_t decode_word(input logic [15:0] iw);
        dec_t r;
        r.zero_form = (iw[15:10] == OPC_DEC_SKIP_Z);
        r.legal     = r.zero_form || (iw[15:10] == OPC_DEC_SKIP_NZ);
        r.to_file   = iw[9];
        r.use_bank  = iw[8];
        r.foff      = iw[7:0];
        return r;
    endfunction

endpackage

// File: rtl/dskip_addr_gen.sv
// Operand address former. Purely combinational.
// Assumes ADDR_W = BANK_W + F_W and ACC_SPLIT fits in F_W bits.
// Picks bank mode, indexed mode (extended, low offsets only) or the
// split access bank (low page / top page).
module dskip_addr_gen #(
    parameter int BANK_W    = 4,
    parameter int F_W       = 8,
    parameter int ADDR_W    = BANK_W + F_W,
    parameter int ACC_SPLIT = 'h60
) (
    input  logic              use_bank,
    input  logic              ext_en,
    input  logic [F_W-1:0]    foff,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - F_W;
    localparam logic [F_W-1:0] SPLIT = F_W'(ACC_SPLIT);

    logic low_off;
    assign low_off = (foff < SPLIT);

    // Select the address source by mode.
    always_comb begin
        if (use_bank)
            addr = {bank, foff};
        else if (ext_en && low_off)
            addr = base + {{HI_W{1'b0}}, foff};
        else if (low_off)
            addr = {{HI_W{1'b0}}, foff};
        else
            addr = {{HI_W{1'b1}}, foff};
    end
endmodule

// File: rtl/dskip_seq.sv
// Phase and no-op cycle sequencer. Accepts start only when idle, runs four
// phases of execution, then 0, 1 or 2 four-phase no-op cycles on a skip.
// Assumes skip_now is valid during the last execution phase.
module dskip_seq
    import dskip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       skip_now,
    input  logic       two_word,
    output logic       accept,
    output logic       in_exec,
    output logic       in_nop,
    output logic [1:0] phase,
    output logic [1:0] skip_cnt
);
    seq_state_e st_q;
    logic [1:0] ph_q;
    logic [1:0] nop_left_q;
    logic [1:0] skip_cnt_q;

    assign accept   = (st_q == ST_IDLE) && start;
    assign in_exec  = (st_q == ST_EXEC);
    assign in_nop   = (st_q == ST_NOP);
    assign phase    = ph_q;
    assign skip_cnt = skip_cnt_q;

    // Advance phases and choose the flush length at the end of Q4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            ph_q       <= 2'd0;
            nop_left_q <= 2'd0;
            skip_cnt_q <= 2'd0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    ph_q <= 2'd0;
                    if (start) begin
                        st_q       <= ST_EXEC;
                        skip_cnt_q <= 2'd0;
                    end
                end
                ST_EXEC: begin
                    ph_q <= ph_q + 2'd1;
                    if (ph_q == 2'd3) begin
                        if (skip_now) begin
                            st_q       <= ST_NOP;
                            nop_left_q <= two_word ? 2'd2 : 2'd1;
                            skip_cnt_q <= two_word ? 2'd2 : 2'd1;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                ST_NOP: begin
                    ph_q <= ph_q + 2'd1;
                    if (ph_q == 2'd3) begin
                        nop_left_q <= nop_left_q - 2'd1;
                        if (nop_left_q == 2'd1) st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // A flush only begins straight after the last execution phase.
    assert_flush_after_q4_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_nop) |-> $past(in_exec && ph_q == 2'd3));
    // Reported no-op count never exceeds two.
    assert_skip_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        skip_cnt_q <= 2'd2);
endmodule

// File: rtl/dskip_exec.sv
// Top of the decrement-and-skip executor. Latches the instruction and its
// addressing context at start, reads the operand in Q2, decrements in Q3,
// writes W or the file in Q4, and requests a flush on a skip.
// Assumes rf_rdata is a combinational function of rf_addr.
module dskip_exec
    import dskip_pkg::*;
#(
    parameter int BANK_W    = 4,
    parameter int F_W       = 8,
    parameter int DATA_W    = 8,
    parameter int ACC_SPLIT = 'h60,
    parameter int ADDR_W    = BANK_W + F_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       instr,
    input  logic              ext_en,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [ADDR_W-1:0] idx_base,
    input  logic              next_two_word,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_rd_en,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              w_we,
    output logic [DATA_W-1:0] w_data,
    output logic              flush_req,
    output logic [1:0]        skip_cycles,
    output logic              illegal,
    output logic              busy,
    output logic [1:0]        q_phase
);
    logic [15:0]       iw_q;
    logic              ext_q;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] res_q;
    logic              illegal_q;
    dec_t              dec;
    logic              accept, in_exec, in_nop, skip_now;
    logic [1:0]        phase;

    assign dec = decode_word(iw_q);

    dskip_addr_gen #(
        .BANK_W(BANK_W), .F_W(F_W), .ADDR_W(ADDR_W), .ACC_SPLIT(ACC_SPLIT)
    ) addr_i (
        .use_bank(dec.use_bank),
        .ext_en  (ext_q),
        .foff    (dec.foff[F_W-1:0]),
        .bank    (bank_q),
        .base    (base_q),
        .addr    (rf_addr)
    );

    // Skip decision from the opcode's sense and the Q3 result.
    assign skip_now = dec.legal && (dec.zero_form ? (res_q == '0) : (res_q != '0));

    dskip_seq seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .skip_now(skip_now),
        .two_word(next_two_word),
        .accept  (accept),
        .in_exec (in_exec),
        .in_nop  (in_nop),
        .phase   (phase),
        .skip_cnt(skip_cycles)
    );

    // Capture the instruction context when a new instruction is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iw_q   <= '0;
            ext_q  <= 1'b0;
            bank_q <= '0;
            base_q <= '0;
        end else if (accept) begin
            iw_q   <= instr;
            ext_q  <= ext_en;
            bank_q <= bank_sel;
            base_q <= idx_base;
        end
    end

    // Operand read (Q2), decrement (Q3) and decode flag (Q1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q    <= '0;
            res_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            if (accept) illegal_q <= 1'b0;
            else if (in_exec && phase == 2'd0) illegal_q <= !dec.legal;
            if (in_exec && phase == 2'd1 && dec.legal) opnd_q <= rf_rdata;
            if (in_exec && phase == 2'd2) res_q <= opnd_q - DATA_W'(1);
        end
    end

    assign rf_rd_en    = in_exec && (phase == 2'd1) && dec.legal;
    assign rf_wr_en    = in_exec && (phase == 2'd3) && dec.legal && dec.to_file;
    assign w_we        = in_exec && (phase == 2'd3) && dec.legal && !dec.to_file;
    assign rf_wdata    = res_q;
    assign w_data      = res_q;
    assign flush_req   = in_nop;
    assign illegal     = illegal_q;
    assign busy        = in_exec || in_nop;
    assign q_phase     = phase;

    // Only one destination is written per instruction.
    assert_one_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_en && w_we));
    // No write lands while the discarded instruction is being flushed.
    assert_no_write_in_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> !(rf_wr_en || w_we));
    // A rejected opcode stays silent on every strobe.
    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(rf_rd_en || rf_wr_en || w_we || flush_req));
    // Reads happen only in the second phase of an execution cycle.
    assert_read_in_q2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en |-> (busy && q_phase == 2'd1 && !flush_req));
    // A write is followed by leaving Q4.
    assert_write_leaves_q4_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en || w_we) |=> (q_phase == 2'd0));
endmodule

// File: tb/dskip_exec_tb_top.sv
module dskip_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        ext_en = 1'b0;
    logic [3:0]  bank_sel = '0;
    logic [11:0] idx_base = '0;
    logic        next_two_word = 1'b0;
    logic [7:0]  rd_val = '0;
    logic [11:0] rf_addr;
    logic        rf_rd_en, rf_wr_en, w_we, flush_req, illegal, busy;
    logic [7:0]  rf_rdata, rf_wdata, w_data;
    logic [1:0]  skip_cycles, q_phase;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;
    assign rf_rdata = rd_val;

    dskip_exec dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .ext_en(ext_en), .bank_sel(bank_sel), .idx_base(idx_base),
        .next_two_word(next_two_word), .rf_addr(rf_addr), .rf_rd_en(rf_rd_en),
        .rf_rdata(rf_rdata), .rf_wr_en(rf_wr_en), .rf_wdata(rf_wdata),
        .w_we(w_we), .w_data(w_data), .flush_req(flush_req),
        .skip_cycles(skip_cycles), .illegal(illegal), .busy(busy), .q_phase(q_phase)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_addr(input bit a, input bit ext,
            input logic [7:0] f, input logic [3:0] bk, input logic [11:0] base);
        if (a) return {bk, f};                                  // R5
        if (ext && f <= 8'h5F) return base + {4'h0, f};         // R7
        if (f < 8'h60) return {4'h0, f};                        // R6
        return {4'hF, f};
    endfunction

    task automatic run_one(input logic [5:0] opc, input bit d, input bit a,
            input logic [7:0] f, input logic [3:0] bk, input bit ext,
            input logic [11:0] base, input logic [7:0] v, input bit two);
        bit legal, zf, skip;
        logic [7:0] res;
        int nexp, n;
        legal = (opc == 6'b001011) || (opc == 6'b010011);       // R1
        zf    = (opc == 6'b001011);
        res   = v - 8'd1;                                       // R3
        skip  = legal && (zf ? (res == 8'h00) : (res != 8'h00));
        nexp  = skip ? (two ? 2 : 1) : 0;
        @(negedge clk);
        instr = {opc, d, a, f}; ext_en = ext; bank_sel = bk; idx_base = base;
        rd_val = v; next_two_word = two; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && q_phase == 2'd0, "R2 Q1 phase", q_phase, 0);
        @(negedge clk);
        chk(rf_rd_en == legal && !rf_wr_en && !w_we, "R2 read strobe in Q2", rf_rd_en, legal);
        chk(illegal == !legal, "R10 illegal flag", illegal, !legal);
        if (legal)
            chk(rf_addr == exp_addr(a, ext, f, bk, base), "R5/R6/R7 address",
                rf_addr, exp_addr(a, ext, f, bk, base));
        @(negedge clk);
        chk(!rf_rd_en && !rf_wr_en && !w_we && q_phase == 2'd2, "R2 Q3 quiet", q_phase, 2);
        @(negedge clk);
        chk(rf_wr_en == (legal && d) && w_we == (legal && !d), "R4 destination select",
            {rf_wr_en, w_we}, {legal && d, legal && !d});
        if (legal) begin
            chk((d ? rf_wdata : w_data) == res, "R3 decremented value",
                d ? rf_wdata : w_data, res);
            if (d) chk(rf_addr == exp_addr(a, ext, f, bk, base), "R4 write address",
                       rf_addr, exp_addr(a, ext, f, bk, base));
        end
        n = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!busy) break;
            n++;
            chk(flush_req && !rf_wr_en && !w_we, "R8 flush during no-op", flush_req, 1);
        end
        chk(n == 4 * nexp, "R8 flush length", n, 4 * nexp);
        chk(skip_cycles == nexp, "R9 skip count", skip_cycles, nexp);
        chk(illegal == !legal, "R10 flag held", illegal, !legal);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<190000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [5:0] opcs [4];
        logic [7:0] fs   [6];
        logic [7:0] vs   [5];
        opcs = '{6'b001011, 6'b010011, 6'b001010, 6'b110011};
        fs   = '{8'h00, 8'h01, 8'h5F, 8'h60, 8'h9A, 8'hFF};
        vs   = '{8'h00, 8'h01, 8'h02, 8'h80, 8'hFF};
        repeat (3) @(negedge clk);
        chk(!busy && !flush_req && !rf_rd_en && !rf_wr_en && !w_we && !illegal
            && skip_cycles == 2'd0, "R11 reset state", busy, 0);
        rst_n = 1'b1;
        for (int oi = 0; oi < 4; oi++)
            for (int d = 0; d < 2; d++)
                for (int a = 0; a < 2; a++)
                    for (int fi = 0; fi < 6; fi++)
                        for (int e = 0; e < 2; e++)
                            for (int t = 0; t < 2; t++)
                                for (int vi = 0; vi < 5; vi++)
                                    run_one(opcs[oi], d[0], a[0], fs[fi],
                                            4'(fi * 3 + vi + 1), e[0],
                                            vi[0] ? 12'hFC0 : 12'h1A3, vs[vi], t[0]);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule